// File: doc/BRIEF.md
# Prescaled Scanline Interrupt Timer

This block is a programmable interrupt timer that advances once per CPU clock. An 8-bit up-counter is preloaded from a latch. When the counter is clocked while it holds 0xFF it reloads from the latch and raises a pending interrupt. The interrupt line is a level that stays high until software clears it. The timer runs in one of two modes:

- **Cycle mode:** the counter is clocked on every CPU cycle.
- **Scanline mode:** a fractional prescaler sets the rate. The prescaler holds a budget of 341 dot units and spends 3 of them each CPU cycle. Each time the budget runs out it is topped up by 341 and the counter is clocked once. Over time this gives one count per 113⅔ CPU cycles.

Software reaches the block through a write strobe, a 2-bit register select and an 8-bit data bus. There are three registers:

- **Latch (select 0):** holds the 8-bit reload value.
- **Control (select 1):** data bit 0 is a saved "enable after acknowledge" value, bit 1 is the enable, and bit 2 picks the mode (1 = cycle, 0 = scanline).
- **Acknowledge (select 2):** clears the interrupt and copies the saved bit into the enable.

Select 3 is unused.

A small run-state machine steers counting. It has three states:

- **ST_OFF:** nothing counts.
- **ST_CYCLE:** the counter is clocked every cycle.
- **ST_LINE:** the prescaler runs and clocks the counter on each top-up.

The transitions are:

- **ctrl write:** goes to ST_OFF when bit 1 = 0. Otherwise it goes to ST_CYCLE or ST_LINE, picked by bit 2.
- **ack write:** goes to ST_OFF when the saved bit = 0. Otherwise it goes to the state that the stored mode names.
- **Any other cycle:** the state holds.

Top module: `scanline_irq_timer`

## Requirements
- R1: After reset the latch and counter are 0, the run state is ST_OFF, the prescaler holds 341 and `irq` is low. Nothing counts until a control write sets the enable.
- R2: A write with select 0 loads the latch. It does not disturb the running counter. The new value is used at the next reload.
- R3: A write with select 1 does three things: it stores data bit 0 as the saved enable, bit 1 as the enable and bit 2 as the mode, and it clears the pending interrupt. When bit 1 is set, it also loads the counter from the latch and sets the prescaler back to 341.
- R4: When the counter is clocked at 0xFF it reloads from the latch and sets pending. When it is clocked at any other value it adds one. In cycle mode it is clocked every cycle.
- R5: In scanline mode the prescaler drops by 3 each cycle. When the result is zero or below, 341 is added back and the counter is clocked once. The stored prescaler value therefore always lies in 1..341.
- R6: A write with select 2 clears pending and loads the enable from the saved bit. The mode is kept.
- R7: While the enable is clear the counter and the prescaler hold, and no interrupt is raised.
- R8: `irq` equals the pending flag. It stays high until a write with select 1 or 2 clears it.
- R9: A write with select 3 changes no state. Counting goes on as if no write occurred.
- R10: In a cycle with a write to select 1 or 2, that write decides the result and no counting takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 latch, 1 control, 2 acknowledge, 3 unused |
| wr_data | input | 8 | Write data |
| irq | output | 1 | Level interrupt request |

## Verification
Cycle mode is tried with latches near 0xFF, so that short, exact overflow intervals show off-by-one errors in the count and the reload. Scanline mode is run for hundreds of cycles with acknowledges that keep the timer enabled. The irq edges can only line up if the prescaler top-up of 341 and the step of 3 are both right. Further patterns are placed around a wrap: acknowledge and control writes on the wrap cycle, unused-select writes, latch writes while counting, and an acknowledge with the saved bit clear. These separate write precedence, the ignored select, reload timing and the disable path.

// File: rtl/irq_timer_pkg.sv
package irq_timer_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_CYCLE = 2'd1,
        ST_LINE  = 2'd2
    } run_state_e;

    localparam logic [1:0] SEL_LATCH = 2'd0;
    localparam logic [1:0] SEL_CTRL  = 2'd1;
    localparam logic [1:0] SEL_ACK   = 2'd2;

    localparam int CTL_ACKEN_BIT = 0;
    localparam int CTL_EN_BIT    = 1;
    localparam int CTL_MODE_BIT  = 2;

endpackage

// File: rtl/irq_prescaler.sv
module irq_prescaler #(
    parameter int PRE_W  = 10,
    parameter int PERIOD = 341,
    parameter int STEP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic line_pulse
);
    localparam logic [PRE_W-1:0] PERIOD_V = PRE_W'(PERIOD);
    localparam logic [PRE_W-1:0] STEP_V   = PRE_W'(STEP);

    logic [PRE_W-1:0] acc_q;
    logic [PRE_W-1:0] acc_dec;
    logic             spent;

    always_comb begin
        acc_dec    = acc_q - STEP_V;
        spent      = acc_dec[PRE_W-1] || (acc_dec == '0);
        line_pulse = run && spent;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc_q <= PERIOD_V;
        end else if (run) begin
            acc_q <= spent ? acc_dec + PERIOD_V : acc_dec;
        end
    end

    assert_pre_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q >= PRE_W'(1)) && (acc_q <= PERIOD_V));

    assert_pre_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(acc_q));

endmodule

// File: rtl/irq_up_counter.sv
module irq_up_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] reload_val,
    output logic [CW-1:0] count,
    output logic          wrap
);
    logic [CW-1:0] cnt_q;

    assign count = cnt_q;
    assign wrap  = tick && (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload_val;
        end else if (tick) begin
            cnt_q <= (cnt_q == '1) ? reload_val : cnt_q + CW'(1);
        end
    end

    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/irq_ctrl_fsm.sv
module irq_ctrl_fsm
    import irq_timer_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [CW-1:0] wr_data,
    input  logic          line_pulse,
    input  logic          wrap,
    output logic          pre_run,
    output logic          pre_restart,
    output logic          cnt_tick,
    output logic          cnt_load,
    output logic [CW-1:0] latch_val,
    output logic          pending,
    output run_state_e    state
);
    run_state_e    state_q, state_d;
    logic [CW-1:0] latch_q;
    logic          ackb_q, mode_q, pend_q;
    logic          ctl_w, ack_w, lat_w, busy_w;

    assign ctl_w  = wr_en && (wr_sel == SEL_CTRL);
    assign ack_w  = wr_en && (wr_sel == SEL_ACK);
    assign lat_w  = wr_en && (wr_sel == SEL_LATCH);
    assign busy_w = ctl_w || ack_w;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ctl_w) begin
            if (!wr_data[CTL_EN_BIT])       state_d = ST_OFF;
            else if (wr_data[CTL_MODE_BIT]) state_d = ST_CYCLE;
            else                            state_d = ST_LINE;
        end else if (ack_w) begin
            if (!ackb_q)     state_d = ST_OFF;
            else if (mode_q) state_d = ST_CYCLE;
            else             state_d = ST_LINE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs per state
    always_comb begin
        pre_run     = 1'b0;
        cnt_tick    = 1'b0;
        pre_restart = ctl_w && wr_data[CTL_EN_BIT];
        cnt_load    = ctl_w && wr_data[CTL_EN_BIT];
        unique case (state_q)
            ST_OFF:   ;
            ST_CYCLE: cnt_tick = !busy_w;
            ST_LINE: begin
                pre_run  = !busy_w;
                cnt_tick = !busy_w && line_pulse;
            end
            default:  ;
        endcase
    end

    // register file and pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            ackb_q  <= 1'b0;
            mode_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            if (lat_w) latch_q <= wr_data;
            if (ctl_w) begin
                ackb_q <= wr_data[CTL_ACKEN_BIT];
                mode_q <= wr_data[CTL_MODE_BIT];
            end
            if (busy_w)    pend_q <= 1'b0;
            else if (wrap) pend_q <= 1'b1;
        end
    end

    assign latch_val = latch_q;
    assign pending   = pend_q;
    assign state     = state_q;

    assert_ack_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_w && !ackb_q) |=> (state_q == ST_OFF));

    assert_busy_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> !cnt_tick);

endmodule

// File: rtl/scanline_irq_timer.sv
module scanline_irq_timer
    import irq_timer_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PRE_W      = 10,
    parameter int DOT_PERIOD = 341,
    parameter int DOT_STEP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq
);
    logic             pre_run, pre_restart, line_pulse;
    logic             cnt_tick, cnt_load, wrap, pending;
    logic [CNT_W-1:0] latch_val, count;
    run_state_e       state;

    irq_ctrl_fsm #(.CW(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .line_pulse (line_pulse),
        .wrap       (wrap),
        .pre_run    (pre_run),
        .pre_restart(pre_restart),
        .cnt_tick   (cnt_tick),
        .cnt_load   (cnt_load),
        .latch_val  (latch_val),
        .pending    (pending),
        .state      (state)
    );

    irq_prescaler #(.PRE_W(PRE_W), .PERIOD(DOT_PERIOD), .STEP(DOT_STEP)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (pre_run),
        .restart   (pre_restart),
        .line_pulse(line_pulse)
    );

    irq_up_counter #(.CW(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_tick),
        .load      (cnt_load),
        .reload_val(latch_val),
        .count     (count),
        .wrap      (wrap)
    );

    assign irq = pending;

    assert_irq_from_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(count) == '1));

    assert_ctrl_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL) |=> !irq);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ACK) |=> !irq);

    assert_off_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !(wr_en && wr_sel == SEL_CTRL)) |=> ($stable(count) && !$rose(irq)));

    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && (wr_sel == SEL_CTRL || wr_sel == SEL_ACK))) |=> irq);

endmodule

// File: tb/scanline_irq_timer_bench.sv
module scanline_irq_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanline_irq_timer u_scanline_irq_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq(irq)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural model state
    int m_latch = 0, m_cnt = 0, m_pre = 341;
    bit m_en = 0, m_mode = 0, m_ackb = 0, m_pend = 0;

    task automatic step(input bit w, input logic [1:0] s, input logic [7:0] d);
        bit ctl_w, ack_w, tick;
        wr_en = w; wr_sel = s; wr_data = d;
        @(posedge clk);
        ctl_w = w && s == 2'd1;
        ack_w = w && s == 2'd2;
        tick  = 0;
        if (m_en && !ctl_w && !ack_w) begin
            if (m_mode) tick = 1;
            else begin
                m_pre -= 3;
                if (m_pre <= 0) begin m_pre += 341; tick = 1; end
            end
        end
        if (tick) begin
            if (m_cnt == 255) begin m_cnt = m_latch; m_pend = 1; end
            else m_cnt++;
        end
        if (w && s == 2'd0) m_latch = d;
        if (ctl_w) begin
            m_ackb = d[0]; m_en = d[1]; m_mode = d[2]; m_pend = 0;
            if (m_en) begin m_cnt = m_latch; m_pre = 341; end
        end
        if (ack_w) begin m_pend = 0; m_en = m_ackb; end
        q.push_back('{m_pend, cur_req});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 2'd0, 8'd0);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        item_t it;
        if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (irq !== it.exp) begin
                errors++;
                $display("FAIL %s: irq=%0b expected %0b at %0t", it.tag, irq, it.exp, $time);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: expired, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (irq !== 1'b0) begin
            errors++;
            $display("FAIL R1: irq=%0b in reset, expected 0", irq);
        end
        rst_n = 1'b1;

        cur_req = "R1";   idle(40);
        cur_req = "R7";   step(1, 2'd0, 8'hFE); idle(300);

        // cycle mode near wrap, saved enable clear
        cur_req = "R4";   step(1, 2'd0, 8'hFC); step(1, 2'd1, 8'h06); idle(12);
        cur_req = "R8";   idle(20);
        cur_req = "R6";   step(1, 2'd2, 8'h00);
        cur_req = "R7";   idle(300);

        // saved enable set: ack keeps it running
        cur_req = "R3";   step(1, 2'd0, 8'hF0); step(1, 2'd1, 8'h07); idle(20);
        cur_req = "R6";   step(1, 2'd2, 8'h00); idle(40);

        // write precedence at wrap
        cur_req = "R10";  step(1, 2'd0, 8'hFE); step(1, 2'd1, 8'h07); idle(1);
        step(1, 2'd2, 8'h00); idle(3);
        step(1, 2'd1, 8'h07); idle(1); step(1, 2'd1, 8'h07); idle(4);

        // unused select while counting
        cur_req = "R9";   step(1, 2'd0, 8'hF8); step(1, 2'd1, 8'h07);
        for (int i = 0; i < 12; i++) step(1, 2'd3, 8'hFF);
        idle(4);

        // latch write mid-count
        cur_req = "R2";   step(1, 2'd0, 8'hF8); step(1, 2'd1, 8'h07); idle(2);
        step(1, 2'd0, 8'h00); idle(8);
        step(1, 2'd2, 8'h00); idle(270);

        // scanline mode with periodic acknowledge
        cur_req = "R5";   step(1, 2'd0, 8'hFE); step(1, 2'd1, 8'h03);
        for (int i = 0; i < 1200; i++) begin
            if (m_pend) step(1, 2'd2, 8'h00);
            else        step(0, 2'd0, 8'h00);
        end
        cur_req = "R5";   step(1, 2'd0, 8'hFF); step(1, 2'd1, 8'h03);
        for (int i = 0; i < 700; i++) begin
            if (m_pend) step(1, 2'd2, 8'h00);
            else        step(0, 2'd0, 8'h00);
        end

        // disable mid scanline
        cur_req = "R7";   step(1, 2'd1, 8'h00); idle(600);

        idle(2);
        #(CLK_PERIOD);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule